// File: doc/BRIEF.md
# Four-Channel Down-Counter Timer with Prioritised Vectored Interrupts

The block gives a host processor four independent 8-bit down-counting channels, all reached through one byte-wide register port. A two-bit channel address and a single-edge write strobe select which channel takes a byte. Each channel runs in one of two ways. As an event counter, it steps on the chosen edge of its own external trigger pin. As a timer, it steps once every 16 or 256 system clocks. When a channel's count runs out, it reloads its stored time constant, emits a one-cycle zero-count pulse and, if enabled, raises an interrupt request.

The requests pass through a daisy chain. Channel 0 has the highest priority, and one enable-in/enable-out pair links the block to its neighbours on the board. During an acknowledge, the block returns a vector byte whose bits 2:1 name the winning channel. An end-of-service strobe then releases that channel. While no acknowledge is in progress, the host can read the live count of any channel.

Top module: `quad_timer`

## Requirements
- R1: After reset every channel is stopped, reads a count of 0x00, and ignores its trigger pin. `int_req` is low and `ieo` follows `iei`. A channel starts only after a time-constant byte is written.
- R2: A control word is a byte with bit 0 = 1. Its fields are: bit 7 interrupt enable, bit 6 mode (1 event counter, 0 timer), bit 5 prescale (1 = 256, 0 = 16), bit 4 edge (1 rising, 0 falling), bit 3 timer waits for trigger, bit 2 time constant follows, bit 1 channel reset. The byte written after a control word with bit 2 set is the time constant. Writing it to a stopped channel loads the count and starts the channel.
- R3: A time constant of 0x00 counts 256 steps. The count reads 0x00 right after loading and 0xFF after one step.
- R4: In timer mode, consecutive zero-count pulses are 16×N system clocks apart, or 256×N with bit 5 set, where N is the time constant.
- R5: In counter mode, the count steps by one on each edge of the selected polarity at the channel's trigger pin. Edges of the other polarity are ignored.
- R6: A timer written with bit 3 set holds its count until the selected trigger edge arrives, then starts timing.
- R7: When a count runs out, the channel reloads its time constant and pulses its `zc_out` bit for one cycle. If interrupts are enabled, it raises `int_req` and pulls `ieo` low.
- R8: A byte with bit 0 = 0 written to channel 0, when no time constant is expected, sets the vector base. On a rising `iack`, `bus_rdata` returns the base with bits 2:1 replaced by the number of the highest-priority requesting channel, where channel 0 is highest.
- R9: While `iei` is low, `int_req` and `ieo` are both low. `ieo` is also low while any channel has a request pending or in service.
- R10: An in-service channel blocks lower-priority requests. A rising `svc_done` ends service for the highest-priority channel in service, after which a waiting lower request is presented again.
- R11: A control word with bit 1 set stops the channel, drops its pending request and freezes its count.
- R12: A write strobe held high for several cycles updates a register exactly once.
- R13: A time constant written to a running channel leaves the current count alone and takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select for register access |
| bus_wr | input | 1 | Write strobe; acted on at its rising edge |
| bus_rd | input | 1 | Read enable for the live count |
| bus_ch | input | 2 | Channel address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Count of the addressed channel, or the vector during acknowledge |
| trig_in | input | 4 | Per-channel external clock/trigger pins (asynchronous) |
| zc_out | output | 4 | One-cycle pulse per channel when its count runs out |
| int_req | output | 1 | Interrupt request, active high |
| iack | input | 1 | Interrupt acknowledge; its rising edge selects the winner |
| svc_done | input | 1 | End-of-service strobe; its rising edge releases a channel |
| iei | input | 1 | Daisy-chain enable in from higher-priority devices |
| ieo | output | 1 | Daisy-chain enable out to lower-priority devices |

## Verification
The bench targets the zero time constant. A design that loaded a plain zero into an 8-bit counter would either wrap at once or never reach its reload, so the bench counts exactly 256 edges and checks for a single zero-count pulse. It acknowledges two requests that were pending together, one after the other. A design with the priority reversed, or one that let an in-service channel stop blocking lower requests, would return the wrong vector or raise `int_req` before `svc_done`. The bench holds a time-constant write for six cycles. A design that sampled the strobe as a level would take the repeated byte as a second control word and switch the channel into timer mode. The bench also writes a new constant to a running channel and checks that it takes hold only at the next reload.

// File: rtl/quad_timer_pkg.sv
package quad_timer_pkg;

    localparam int DATA_W = 8;

    // Decoded per-channel configuration, captured from a control word
    typedef struct packed {
        logic int_en;
        logic counter_mode;
        logic pre_long;
        logic edge_rise;
        logic trig_start;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_t;

    // Loaded count for a time constant; zero stands for a full 2**DATA_W span
    function automatic logic [DATA_W:0] count_span(input logic [DATA_W-1:0] tc);
        if (tc == '0)
            return {1'b1, {DATA_W{1'b0}}};
        else
            return {1'b0, tc};
    endfunction

endpackage

// File: rtl/qt_trig_sync.sv
module qt_trig_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= pin_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_o = s2 & ~s3;
    assign fall_o = ~s2 & s3;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R5: one physical edge yields one step request, never two in a row
        a_r5_single_rise: assert property (@(posedge clk) disable iff (rst)
            rise_o[i] |=> !rise_o[i]) else $error("a_r5_single_rise");
        a_r5_single_fall: assert property (@(posedge clk) disable iff (rst)
            fall_o[i] |=> !fall_o[i]) else $error("a_r5_single_fall");
    end
endmodule

// File: rtl/qt_channel.sv
module qt_channel
    import quad_timer_pkg::*;
#(
    parameter int CW        = DATA_W,
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          trig_rise,
    input  logic          trig_fall,
    input  logic          ack_clr,
    output logic [CW:0]   cnt_o,
    output logic          zc_o,
    output logic          pend_o,
    output logic          await_o
);
    localparam int PREW = $clog2(PRE_LONG);
    localparam logic [PREW-1:0] LIM_SHORT = PREW'(PRE_SHORT - 1);
    localparam logic [PREW-1:0] LIM_LONG  = PREW'(PRE_LONG - 1);
    localparam logic [CW:0]     CNT_ONE   = (CW+1)'(1);

    chan_cfg_t       cfg;
    ch_state_t       state;
    logic [CW-1:0]   tc;
    logic [CW:0]     cnt;
    logic [PREW-1:0] pre;
    logic            await_tc;
    logic            zc, pend;

    logic            trig_act;
    logic [PREW-1:0] pre_lim;
    logic            tick;

    always_comb begin
        trig_act = cfg.edge_rise ? trig_rise : trig_fall;
        pre_lim  = cfg.pre_long ? LIM_LONG : LIM_SHORT;
        tick     = (state == CH_RUN) &&
                   (cfg.counter_mode ? trig_act : (pre == pre_lim));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            state    <= CH_IDLE;
            tc       <= '0;
            cnt      <= '0;
            pre      <= '0;
            await_tc <= 1'b0;
            zc       <= 1'b0;
            pend     <= 1'b0;
        end else begin
            zc <= 1'b0;
            if (ack_clr)
                pend <= 1'b0;

            if (state == CH_RUN && !cfg.counter_mode)
                pre <= (pre == pre_lim) ? '0 : pre + 1'b1;

            if (tick) begin
                if (cnt == CNT_ONE) begin
                    cnt <= count_span(tc);
                    zc  <= 1'b1;
                    if (cfg.int_en)
                        pend <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end

            if (state == CH_ARMED && trig_act) begin
                state <= CH_RUN;
                pre   <= '0;
            end

            if (wr_en) begin
                if (await_tc) begin
                    tc       <= wr_data;
                    await_tc <= 1'b0;
                    if (state == CH_IDLE) begin
                        cnt   <= count_span(wr_data);
                        pre   <= '0;
                        state <= (!cfg.counter_mode && cfg.trig_start) ? CH_ARMED : CH_RUN;
                    end
                end else if (wr_data[0]) begin
                    cfg.int_en       <= wr_data[7];
                    cfg.counter_mode <= wr_data[6];
                    cfg.pre_long     <= wr_data[5];
                    cfg.edge_rise    <= wr_data[4];
                    cfg.trig_start   <= wr_data[3];
                    await_tc         <= wr_data[2];
                    if (wr_data[1]) begin
                        state <= CH_IDLE;
                        pend  <= 1'b0;
                        pre   <= '0;
                    end
                end
            end
        end
    end

    assign cnt_o   = cnt;
    assign zc_o    = zc;
    assign pend_o  = pend;
    assign await_o = await_tc;

    // R3: a running count never rests at zero, a full span is 9 bits
    a_r3_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        (state == CH_RUN) |-> (cnt != '0)) else $error("a_r3_count_nonzero");

    // R7: reaching zero with interrupts enabled leaves a request behind
    a_r7_zero_requests: assert property (@(posedge clk) disable iff (rst)
        (zc && cfg.int_en && !$past(wr_en)) |-> pend) else $error("a_r7_zero_requests");

    // R11/R6: a stopped or armed channel keeps its count
    a_r11_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (state != CH_RUN && !wr_en) |=> $stable(cnt)) else $error("a_r11_stopped_hold");
endmodule

// File: rtl/qt_chain.sv
module qt_chain #(
    parameter int NCH  = 4,
    parameter int CW   = 8,
    parameter int SELW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH-1:0]     pend_i,
    input  logic               iei,
    input  logic               ack_pulse,
    input  logic               done_pulse,
    input  logic               vec_we,
    input  logic [CW-SELW-2:0] vec_hi,
    output logic [NCH-1:0]     ack_clr,
    output logic               int_req,
    output logic               ieo,
    output logic [CW-1:0]      vec_o
);
    logic [NCH-1:0]     insvc;
    logic [NCH-1:0]     req, done_sel;
    logic [SELW-1:0]    sel;
    logic [CW-SELW-2:0] base;
    logic               en;

    always_comb begin
        en       = iei;
        req      = '0;
        done_sel = '0;
        sel      = '0;
        for (int i = 0; i < NCH; i++) begin
            req[i]      = pend_i[i] & en;
            done_sel[i] = insvc[i] & en;
            en          = en & ~(pend_i[i] | insvc[i]);
        end
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i])
                sel = SELW'(i);
        end
        ieo     = en;
        int_req = |req;
        ack_clr = ack_pulse ? req : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            insvc <= '0;
            base  <= '0;
            vec_o <= '0;
        end else begin
            insvc <= (insvc & ~(done_pulse ? done_sel : '0)) | ack_clr;
            if (vec_we)
                base <= vec_hi;
            if (ack_pulse)
                vec_o <= {base, sel, 1'b0};
        end
    end

    // R8: at most one channel is eligible at a time
    a_r8_one_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req)) else $error("a_r8_one_winner");

    // R8: an acknowledged request puts a channel in service
    a_r8_ack_services: assert property (@(posedge clk) disable iff (rst)
        (ack_pulse && int_req) |=> (insvc != '0)) else $error("a_r8_ack_services");

    // R9: a low enable-in silences the whole chain
    a_r9_iei_gate: assert property (@(posedge clk) disable iff (rst)
        !iei |-> (!int_req && !ieo)) else $error("a_r9_iei_gate");
endmodule

// File: rtl/quad_timer.sv
module quad_timer
    import quad_timer_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CW        = DATA_W,
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_cs,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [$clog2(NCH)-1:0] bus_ch,
    input  logic [CW-1:0]          bus_wdata,
    output logic [CW-1:0]          bus_rdata,
    input  logic [NCH-1:0]         trig_in,
    output logic [NCH-1:0]         zc_out,
    output logic                   int_req,
    input  logic                   iack,
    input  logic                   svc_done,
    input  logic                   iei,
    output logic                   ieo
);
    localparam int SELW = $clog2(NCH);

    logic            wr_q, iack_q, done_q;
    logic            wr_pulse, ack_pulse, done_pulse;
    logic [NCH-1:0]  rise, fall, pend, await_tc, ack_clr, ch_we;
    logic [CW:0]     cnt_all [NCH];
    logic [CW-1:0]   vec;
    logic            vec_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            iack_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            wr_q   <= bus_cs & bus_wr;
            iack_q <= iack;
            done_q <= svc_done;
        end
    end

    assign wr_pulse   = bus_cs & bus_wr & ~wr_q;
    assign ack_pulse  = iack & ~iack_q;
    assign done_pulse = svc_done & ~done_q;
    assign vec_we     = wr_pulse && (bus_ch == '0) && !await_tc[0] && !bus_wdata[0];

    qt_trig_sync #(.N(NCH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (trig_in),
        .rise_o (rise),
        .fall_o (fall)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_we[i] = wr_pulse && (bus_ch == SELW'(i));
        qt_channel #(
            .CW        (CW),
            .PRE_SHORT (PRE_SHORT),
            .PRE_LONG  (PRE_LONG)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (ch_we[i]),
            .wr_data   (bus_wdata),
            .trig_rise (rise[i]),
            .trig_fall (fall[i]),
            .ack_clr   (ack_clr[i]),
            .cnt_o     (cnt_all[i]),
            .zc_o      (zc_out[i]),
            .pend_o    (pend[i]),
            .await_o   (await_tc[i])
        );
    end

    qt_chain #(.NCH(NCH), .CW(CW), .SELW(SELW)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .pend_i     (pend),
        .iei        (iei),
        .ack_pulse  (ack_pulse),
        .done_pulse (done_pulse),
        .vec_we     (vec_we),
        .vec_hi     (bus_wdata[CW-1:SELW+1]),
        .ack_clr    (ack_clr),
        .int_req    (int_req),
        .ieo        (ieo),
        .vec_o      (vec)
    );

    always_comb begin
        if (iack)
            bus_rdata = vec;
        else if (bus_cs && bus_rd)
            bus_rdata = cnt_all[bus_ch][CW-1:0];
        else
            bus_rdata = '0;
    end

    // R12: a held strobe yields a single write event
    a_r12_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse) else $error("a_r12_single_write");
endmodule

// File: tb/sim_quad_timer.sv
`timescale 1ns/1ps
module sim_quad_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs = 0, bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_ch = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [3:0] trig_in = 0;
    logic [3:0] zc_out;
    logic       int_req, ieo;
    logic       iack = 0, svc_done = 0, iei = 1;

    int checks = 0, errors = 0;
    int cyc = 0;
    int zc_cnt [4] = '{0, 0, 0, 0};
    int zc_last[4] = '{0, 0, 0, 0};
    int zc_gap [4] = '{0, 0, 0, 0};
    bit finished = 0;

    always #4 clk = ~clk;

    quad_timer u0 (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ch(bus_ch), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .zc_out(zc_out), .int_req(int_req), .iack(iack),
        .svc_done(svc_done), .iei(iei), .ieo(ieo)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (!rst && zc_out[i]) begin
                zc_cnt[i]  = zc_cnt[i] + 1;
                zc_gap[i]  = cyc - zc_last[i];
                zc_last[i] = cyc;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [7:0] d, input int hold);
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_ch = 2'(ch); bus_wdata = d;
        repeat (hold) @(negedge clk);
        bus_wr = 0; bus_cs = 0;
        @(negedge clk);
    endtask

    task automatic rd(input int ch, output int v);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_ch = 2'(ch);
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
    endtask

    task automatic pulse(input int ch);
        @(negedge clk);
        trig_in[ch] = 1'b1;
        repeat (5) @(negedge clk);
        trig_in[ch] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic wait_zc(input int ch, input int target);
        for (int k = 0; k < 6000 && zc_cnt[ch] < target; k++)
            @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        for (int i = 0; i < 4; i++) begin
            rd(i, v);
            check("R1 count after reset", v, 0);
        end
        check("R1 int_req after reset", int'(int_req), 0);
        check("R1 ieo follows iei", int'(ieo), 1);
        pulse(0);
        rd(0, v);
        check("R1 stopped channel ignores trigger", v, 0);
        check("R1 no zero pulse when stopped", zc_cnt[0], 0);
    endtask

    task automatic t_counter();
        int v;
        wr(1, 8'h55, 1);          // R2: counter, rising, time constant follows
        wr(1, 8'h05, 1);
        rd(1, v);
        check("R2 loaded count", v, 5);
        pulse(1); pulse(1);
        rd(1, v);
        check("R2 counts rising edges", v, 3);
        wr(2, 8'h45, 1);          // R5: counter, falling edge
        wr(2, 8'h04, 1);
        @(negedge clk); trig_in[2] = 1'b1;
        repeat (6) @(negedge clk);
        rd(2, v);
        check("R5 rising edge ignored on falling select", v, 4);
        trig_in[2] = 1'b0;
        repeat (6) @(negedge clk);
        rd(2, v);
        check("R5 falling edge counted", v, 3);
    endtask

    task automatic t_zero256();
        int v, base;
        wr(3, 8'h55, 1);
        wr(3, 8'h00, 1);
        rd(3, v);
        check("R3 zero constant reads 0x00", v, 0);
        base = zc_cnt[3];
        pulse(3);
        rd(3, v);
        check("R3 first step gives 0xFF", v, 255);
        for (int k = 0; k < 254; k++) pulse(3);
        rd(3, v);
        check("R3 one step left", v, 1);
        check("R3 no early zero", zc_cnt[3], base);
        pulse(3);
        check("R3 zero after 256 steps", zc_cnt[3], base + 1);
        rd(3, v);
        check("R3 reload to 256", v, 0);
    endtask

    task automatic t_timer();
        int v, v2, base;
        wr(0, 8'h05, 1);          // R4: timer, prescale 16
        wr(0, 8'h03, 1);
        base = zc_cnt[0];
        wait_zc(0, base + 2);
        check("R4 period 16 x 3", zc_gap[0], 48);
        wr(0, 8'h03, 1);          // R11: channel reset
        rd(0, v);
        base = zc_cnt[0];
        repeat (100) @(negedge clk);
        rd(0, v2);
        check("R11 count frozen after reset word", v2, v);
        check("R11 no zero pulse after reset word", zc_cnt[0], base);
        wr(0, 8'h25, 1);          // R4: prescale 256
        wr(0, 8'h02, 1);
        base = zc_cnt[0];
        wait_zc(0, base + 2);
        check("R4 period 256 x 2", zc_gap[0], 512);
        wr(0, 8'h03, 1);
    endtask

    task automatic t_trigger();
        int v, base;
        wr(1, 8'h1F, 1);          // R6: timer, waits for rising trigger
        wr(1, 8'h02, 1);
        base = zc_cnt[1];
        repeat (200) @(negedge clk);
        rd(1, v);
        check("R6 armed timer holds count", v, 2);
        check("R6 no zero before trigger", zc_cnt[1], base);
        pulse(1);
        wait_zc(1, base + 1);
        check("R6 starts after trigger", zc_cnt[1], base + 1);
        wr(1, 8'h03, 1);
    endtask

    task automatic t_strobe_and_reload();
        int v, base;
        wr(1, 8'h57, 1);          // counter with reset, time constant follows
        wr(1, 8'h05, 6);          // R12: long strobe
        repeat (40) @(negedge clk);
        pulse(1); pulse(1);
        rd(1, v);
        check("R12 held strobe writes once", v, 3);
        wr(1, 8'h55, 1);          // R13: new constant while running
        wr(1, 8'h08, 1);
        rd(1, v);
        check("R13 running count untouched", v, 3);
        base = zc_cnt[1];
        pulse(1); pulse(1); pulse(1);
        check("R13 zero reached", zc_cnt[1], base + 1);
        rd(1, v);
        check("R13 new constant at reload", v, 8);
        pulse(1);
        rd(1, v);
        check("R13 counts from new constant", v, 7);
    endtask

    task automatic t_irq();
        wr(0, 8'hA0, 1);          // R8: vector base
        wr(3, 8'hD7, 1); wr(3, 8'h01, 1);
        wr(2, 8'hD7, 1); wr(2, 8'h01, 1);
        check("R7 no request yet", int'(int_req), 0);
        pulse(3);
        check("R7 request on zero", int'(int_req), 1);
        check("R9 ieo low while pending", int'(ieo), 0);
        @(negedge clk); iei = 1'b0; #1;
        check("R9 iei low hides request", int'(int_req), 0);
        check("R9 iei low forces ieo low", int'(ieo), 0);
        @(negedge clk); iei = 1'b1;
        pulse(2);
        @(negedge clk); iack = 1'b1;
        @(negedge clk); #1;
        check("R8 vector names channel 2", int'(bus_rdata), 8'hA4);
        iack = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 service blocks lower request", int'(int_req), 0);
        check("R10 ieo low in service", int'(ieo), 0);
        svc_done = 1'b1; @(negedge clk); svc_done = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 lower request after service end", int'(int_req), 1);
        iack = 1'b1;
        @(negedge clk); #1;
        check("R8 vector names channel 3", int'(bus_rdata), 8'hA6);
        iack = 1'b0;
        repeat (2) @(negedge clk);
        svc_done = 1'b1; @(negedge clk); svc_done = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 chain idle after last service", int'(int_req), 0);
        check("R10 ieo restored", int'(ieo), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_counter();
        t_zero256();
        t_timer();
        t_trigger();
        t_strobe_and_reload();
        t_irq();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule